// File: doc/BRIEF.md
# Stereo Audio Serial Engine (I2S / MSB-Justified)

This block is the bit-level engine of a two-channel audio port. It takes one 32-bit word per frame from a transmit FIFO, where the left 16-bit sample sits in the upper half and the right sample in the lower half, and shifts it out on a serial data pin. At the same time it assembles the bits arriving on the serial input into one 32-bit word per frame and pushes that word toward a receive FIFO. Both directions share one bit clock and one frame sync, so both channels always run at the same frame rate.

The engine either generates the bit clock and frame sync itself from the system clock (master) or follows them from pins (slave). Bit-clock edges are detected in the system-clock domain. A single format input selects standard I2S, where each channel's MSB trails the frame-sync edge by one bit clock, or MSB-justified framing, where the MSB sits in the first bit slot. Playback and record can be disabled separately. The link runs only while the global enable is high and at least one of the two directions is still enabled. A loopback input routes the engine's own serial output into its receiver. The FIFO side is a show-ahead pop strobe (`txPop` with `txData` valid in the same cycle) and a one-cycle push strobe (`rxPush` with `rxWord`).

Top module: `audioSerEngine`

## Requirements
- R1: When `enable` is low, or `playDisable` and `recDisable` are both high, the link is off. `bclkOut`, `lrclkOut` and `sdOut` stay low, no bit clock toggles, and neither `txPop` nor `rxPush` is asserted.
- R2: In master mode (`isMaster`=1), `bclkOut` has a period of 2*DIV_HALF system clocks. `lrclkOut` changes only in the cycle in which `bclkOut` falls, and it stays low for 16 bit clocks and then high for 16. `clkDrive` equals `isMaster`.
- R3: With `msbJust`=0 (I2S), the MSB of each channel occupies the second bit slot after the frame-sync transition, both on `sdOut` and on the serial input.
- R4: With `msbJust`=1 (MSB-justified), the MSB of each channel occupies the first bit slot after the frame-sync transition, on both sides.
- R5: Frame sync low marks the left channel and high marks the right. The left sample travels as word bits 31:16, the right sample as bits 15:0, and each is sent MSB first.
- R6: At each frame start (the bit-clock fall that opens the left channel's MSB slot), one word is popped if `txAvail` is high. A frame that starts without a pop sends all zeros. `txPop` never lasts more than one cycle.
- R7: Exactly one word is pushed per frame, after the right channel's LSB has been sampled. Receive alignment starts at the first frame-sync falling edge after the link turns on. The first pushed word is the first complete frame after that edge.
- R8: While `playDisable` is high, `sdOut` is low and no word is popped.
- R9: While `recDisable` is high, no word is pushed.
- R10: With `loopback` high, the receiver samples the engine's own `sdOut` and ignores `sdIn`. With it low, the receiver samples `sdIn`.
- R11: In slave mode, all bit timing follows `bclkIn` and `lrclkIn`. In master mode, `sdOut` changes only while `bclkOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global link enable |
| isMaster | input | 1 | 1: generate bit clock and frame sync; 0: follow the pins |
| msbJust | input | 1 | 0: I2S framing; 1: MSB-justified framing |
| playDisable | input | 1 | Stops transmit: no pops, data output low |
| recDisable | input | 1 | Stops receive: no pushes |
| loopback | input | 1 | Feed serial output into the receiver |
| txData | input | 32 | Show-ahead transmit FIFO word {left, right} |
| txAvail | input | 1 | Transmit FIFO holds a word |
| txPop | output | 1 | Takes `txData` in this cycle |
| rxWord | output | 32 | Received word {left, right} |
| rxPush | output | 1 | `rxWord` is new in this cycle |
| bclkIn | input | 1 | Bit clock from an external master |
| lrclkIn | input | 1 | Frame sync from an external master |
| sdIn | input | 1 | Serial receive data |
| bclkOut | output | 1 | Generated bit clock (master mode) |
| lrclkOut | output | 1 | Generated frame sync (master mode) |
| clkDrive | output | 1 | Output enable for the bit clock and frame sync pads |
| sdOut | output | 1 | Serial transmit data |

## Verification
The bench builds the engine with 16-bit samples and DIV_HALF=3. A bit clock then lasts six system clocks, which puts many frames within the run. The `sdOut` update lands one cycle after the generated fall, with only two cycles of low phase left before the next rising edge. In slave mode the bench plays an external master with a much slower bit clock. This lets it check the one-slot MSB offset of I2S against the zero offset of MSB-justified framing, on both the transmit and the receive side. The loopback runs use single-word FIFO contents. These runs show which frame carries the popped word in each format, and that later frames without a word carry zeros.

// File: rtl/audioSerPkg.sv
package audioSerPkg;

  // Per-cycle strobes from the timing control to the shift datapath.
  typedef struct packed {
    logic rise;        // bit-clock rising edge seen: sample receive bit
    logic fall;        // bit-clock falling edge seen: launch transmit bit
    logic frameStart;  // this fall opens the left MSB slot
    logic pop;         // take a transmit word in this cycle
    logic push;        // the receive word completes on this rise
    logic clear;       // link off: return to idle
  } serStrobe_t;

endpackage

// File: rtl/audioSerCtrl.sv
module audioSerCtrl
  import audioSerPkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int DIV_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       linkOn,
  input  logic       isMaster,
  input  logic       msbJust,
  input  logic       playDisable,
  input  logic       recDisable,
  input  logic       txAvail,
  input  logic       bclkIn,
  input  logic       lrclkIn,
  input  logic       sdIn,
  output logic       bclkOut,
  output logic       lrclkOut,
  output logic       sdLine,
  output serStrobe_t strb
);

  localparam int FRAME = 2 * SAMPLE_W;
  localparam int POS_W = $clog2(FRAME);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  // ---------------- pin synchronizers (slave mode) ----------------
  logic [SYNC_STAGES-1:0] bSync, lSync, dSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      lSync <= '0;
      dSync <= '0;
    end else begin
      bSync <= {bSync[SYNC_STAGES-2:0], bclkIn};
      lSync <= {lSync[SYNC_STAGES-2:0], lrclkIn};
      dSync <= {dSync[SYNC_STAGES-2:0], sdIn};
    end
  end

  // ---------------- master clock generation ----------------
  logic [DIV_W-1:0] divCnt;
  logic [POS_W-1:0] mCnt;
  logic             bclkReg, lrReg;
  logic [POS_W-1:0] mNext;

  assign mNext = mCnt + POS_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN || !(linkOn && isMaster)) begin
      divCnt  <= '0;
      mCnt    <= '0;
      bclkReg <= 1'b0;
      lrReg   <= 1'b0;
    end else if (divCnt == DIV_W'(DIV_HALF - 1)) begin
      divCnt  <= '0;
      bclkReg <= ~bclkReg;
      if (bclkReg) begin
        mCnt  <= mNext;
        lrReg <= mNext[POS_W-1];
      end
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign bclkOut  = bclkReg;
  assign lrclkOut = lrReg;

  // ---------------- line selection and edge detection ----------------
  logic bclkLine, lrLine, bclkPrev;

  assign bclkLine = isMaster ? bclkReg : bSync[SYNC_STAGES-1];
  assign lrLine   = isMaster ? lrReg   : lSync[SYNC_STAGES-1];
  assign sdLine   = isMaster ? sdIn    : dSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) bclkPrev <= 1'b0;
    else       bclkPrev <= bclkLine;
  end

  logic riseNow, fallNow;
  assign riseNow = linkOn && bclkLine && !bclkPrev;
  assign fallNow = linkOn && !bclkLine && bclkPrev;

  // ---------------- frame position tracking ----------------
  logic [POS_W-2:0] slot, slotNow;
  logic             lrLast, locked, armed;
  logic [POS_W-1:0] posReg, posNow, posRaw, nextPos;
  logic             lrChg, lockNow;

  assign lrChg   = lrLine != lrLast;
  assign lockNow = riseNow && lrChg && !lrLine;
  assign slotNow = lrChg ? '0 : slot + (POS_W-1)'(1);
  assign posRaw  = {lrLine, slotNow};
  // I2S data trails the frame-sync edge by one slot.
  assign posNow  = msbJust ? posRaw : posRaw - POS_W'(1);
  assign nextPos = posReg + POS_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN || !linkOn) begin
      lrLast <= 1'b0;
      slot   <= '0;
      locked <= 1'b0;
      armed  <= 1'b0;
      posReg <= '0;
    end else if (riseNow) begin
      lrLast <= lrLine;
      slot   <= slotNow;
      posReg <= posNow;
      if (lockNow) locked <= 1'b1;
      if ((locked || lockNow) && posNow == '0) armed <= 1'b1;
    end
  end

  // ---------------- strobes to the datapath ----------------
  always_comb begin
    strb            = '0;
    strb.clear      = !linkOn;
    strb.rise       = riseNow;
    strb.fall       = fallNow;
    strb.frameStart = fallNow && locked && nextPos == '0;
    strb.pop        = strb.frameStart && txAvail && !playDisable;
    strb.push       = riseNow && locked && armed &&
                      posNow == POS_W'(FRAME - 1) && !recDisable;
  end

endmodule

// File: rtl/audioSerData.sv
module audioSerData
  import audioSerPkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  serStrobe_t              strb,
  input  logic                    playDisable,
  input  logic                    loopback,
  input  logic                    sdLine,
  input  logic [2*SAMPLE_W-1:0]   txData,
  output logic                    sdOut,
  output logic [2*SAMPLE_W-1:0]   rxWord,
  output logic                    rxPush
);

  localparam int FRAME = 2 * SAMPLE_W;

  // ---------------- transmit shifter ----------------
  logic [FRAME-1:0] txShift, loadWord;
  logic             sdReg;

  assign loadWord = strb.pop ? txData : '0;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear || playDisable) begin
      txShift <= '0;
      sdReg   <= 1'b0;
    end else if (strb.fall) begin
      if (strb.frameStart) begin
        sdReg   <= loadWord[FRAME-1];
        txShift <= {loadWord[FRAME-2:0], 1'b0};
      end else begin
        sdReg   <= txShift[FRAME-1];
        txShift <= {txShift[FRAME-2:0], 1'b0};
      end
    end
  end

  assign sdOut = sdReg;

  // ---------------- receive shifter ----------------
  logic             rxBit;
  logic [FRAME-1:0] rxShift;
  logic             pushReg;

  assign rxBit = loopback ? sdReg : sdLine;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      rxShift <= '0;
      pushReg <= 1'b0;
    end else begin
      pushReg <= strb.push;
      if (strb.rise) rxShift <= {rxShift[FRAME-2:0], rxBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rxWord <= '0;
    else if (strb.push) rxWord <= {rxShift[FRAME-2:0], rxBit};
  end

  assign rxPush = pushReg;

endmodule

// File: rtl/audioSerEngine.sv
module audioSerEngine
  import audioSerPkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DIV_HALF = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  isMaster,
  input  logic                  msbJust,
  input  logic                  playDisable,
  input  logic                  recDisable,
  input  logic                  loopback,
  input  logic [2*SAMPLE_W-1:0] txData,
  input  logic                  txAvail,
  output logic                  txPop,
  output logic [2*SAMPLE_W-1:0] rxWord,
  output logic                  rxPush,
  input  logic                  bclkIn,
  input  logic                  lrclkIn,
  input  logic                  sdIn,
  output logic                  bclkOut,
  output logic                  lrclkOut,
  output logic                  clkDrive,
  output logic                  sdOut
);

  serStrobe_t strb;
  logic       linkOn, sdLine;

  assign linkOn   = enable && !(playDisable && recDisable);
  assign clkDrive = isMaster;
  assign txPop    = strb.pop;

  audioSerCtrl #(.SAMPLE_W(SAMPLE_W), .DIV_HALF(DIV_HALF), .SYNC_STAGES(2)) ctrl (
    .clk(clk), .rstN(rstN), .linkOn(linkOn), .isMaster(isMaster),
    .msbJust(msbJust), .playDisable(playDisable), .recDisable(recDisable),
    .txAvail(txAvail), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdIn(sdIn),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .sdLine(sdLine), .strb(strb)
  );

  audioSerData #(.SAMPLE_W(SAMPLE_W)) data (
    .clk(clk), .rstN(rstN), .strb(strb), .playDisable(playDisable),
    .loopback(loopback), .sdLine(sdLine), .txData(txData),
    .sdOut(sdOut), .rxWord(rxWord), .rxPush(rxPush)
  );

endmodule

// File: rtl/audioSerEngineChk.sv
module audioSerEngineChk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic isMaster,
  input logic playDisable,
  input logic recDisable,
  input logic bclkOut,
  input logic lrclkOut,
  input logic sdOut,
  input logic txPop,
  input logic rxPush
);

  logic linkOn;
  assign linkOn = enable && !(playDisable && recDisable);

  assert_off_no_pop_R1: assert property (@(posedge clk) disable iff (!rstN)
    !linkOn |-> !txPop);

  assert_off_no_push_R1: assert property (@(posedge clk) disable iff (!rstN)
    !linkOn && $past(!linkOn) |-> !rxPush);

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !linkOn |=> (!sdOut && !bclkOut && !lrclkOut));

  assert_lr_on_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && $past(isMaster) && linkOn && $past(linkOn) &&
     lrclkOut != $past(lrclkOut)) |-> $fell(bclkOut));

  assert_single_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    txPop |=> !txPop);

  assert_single_push_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> !rxPush);

  assert_play_off_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    playDisable |-> !txPop);

  assert_play_off_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    playDisable |=> !sdOut);

  assert_rec_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    recDisable && $past(recDisable) |-> !rxPush);

  assert_data_on_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && linkOn && $past(linkOn) && !playDisable && !$past(playDisable) &&
     sdOut != $past(sdOut)) |-> !bclkOut);

endmodule

bind audioSerEngine audioSerEngineChk chk (
  .clk(clk), .rstN(rstN), .enable(enable), .isMaster(isMaster),
  .playDisable(playDisable), .recDisable(recDisable), .bclkOut(bclkOut),
  .lrclkOut(lrclkOut), .sdOut(sdOut), .txPop(txPop), .rxPush(rxPush)
);

// File: tb/audioSerEngine_test.sv
module audioSerEngine_test;

  localparam int SW = 16;
  localparam int DH = 3;
  localparam int FW = 2 * SW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, enable, isMaster, msbJust, playDisable, recDisable, loopback;
  logic [FW-1:0] txData, rxWord;
  logic txAvail, txPop, rxPush, bclkIn, lrclkIn, sdIn;
  logic bclkOut, lrclkOut, clkDrive, sdOut;

  audioSerEngine #(.SAMPLE_W(SW), .DIV_HALF(DH)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .isMaster(isMaster),
    .msbJust(msbJust), .playDisable(playDisable), .recDisable(recDisable),
    .loopback(loopback), .txData(txData), .txAvail(txAvail), .txPop(txPop),
    .rxWord(rxWord), .rxPush(rxPush), .bclkIn(bclkIn), .lrclkIn(lrclkIn),
    .sdIn(sdIn), .bclkOut(bclkOut), .lrclkOut(lrclkOut), .clkDrive(clkDrive),
    .sdOut(sdOut)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- FIFO model and output monitor ----------------
  logic [FW-1:0] txQ [16];
  int  txIdx, txCnt, popCount, rxCount, bclkToggles;
  bit  popPend, popSince, sdSeenHigh, lastBclk;
  logic [FW-1:0] lastPop;
  logic [FW-1:0] rxLog [16];
  logic [FW-1:0] expLoop [16];

  assign txData  = txQ[txIdx[3:0]];
  assign txAvail = txIdx < txCnt;

  always @(negedge clk) begin
    if (popPend) txIdx++;
    popPend = txPop;
    if (txPop) begin
      popCount++;
      lastPop  = txQ[txIdx[3:0]];
      popSince = 1'b1;
    end
    if (rxPush) begin
      rxLog[rxCount % 16]   = rxWord;
      expLoop[rxCount % 16] = popSince ? lastPop : '0;
      popSince = 1'b0;
      rxCount++;
    end
    if (bclkOut != lastBclk) bclkToggles++;
    lastBclk = bclkOut;
    if (sdOut) sdSeenHigh = 1'b1;
  end

  task automatic startLink(input bit m, input bit mj, input bit lb,
                           input bit pd, input bit rd);
    @(negedge clk);
    enable = 1'b0;
    repeat (4) @(negedge clk);
    isMaster = m; msbJust = mj; loopback = lb;
    playDisable = pd; recDisable = rd;
    bclkIn = 1'b0; lrclkIn = 1'b1; sdIn = 1'b0;
    txIdx = 0; txCnt = 0; popCount = 0; rxCount = 0;
    popSince = 1'b0; bclkToggles = 0; sdSeenHigh = 1'b0;
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic waitPushes(input int n, input string tag);
    int t;
    t = 0;
    while (rxCount < n && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(rxCount >= n, tag, rxCount, n);
  endtask

  // Bench acting as external master: slot-level drive of the pins.
  logic [FW-1:0] sWords [3];
  logic [FW-1:0] gotTx  [3];

  task automatic slaveRun(input bit mj);
    int j;
    for (int f = 0; f < 3; f++) gotTx[f] = '0;
    for (int p = 0; p < 4; p++) begin
      bclkIn = 1'b0; lrclkIn = 1'b1; sdIn = 1'b0;
      repeat (8) @(negedge clk);
      bclkIn = 1'b1;
      repeat (8) @(negedge clk);
    end
    for (int i = 0; i < 3 * FW + 2; i++) begin
      j = mj ? i : i - 1;
      bclkIn  = 1'b0;
      lrclkIn = (i < 3 * FW) ? ((i % FW) >= SW) : 1'b0;
      sdIn    = (j >= 0 && j < 3 * FW) ? sWords[j / FW][FW - 1 - (j % FW)] : 1'b0;
      repeat (8) @(negedge clk);
      bclkIn = 1'b1;
      repeat (4) @(negedge clk);
      if (j >= 0 && j < 3 * FW) gotTx[j / FW][FW - 1 - (j % FW)] = sdOut;
      repeat (4) @(negedge clk);
    end
    repeat (10) @(negedge clk);
  endtask

  // Stimulus table: bit 32 = msbJust, bits 31:0 = the word sent in loopback.
  localparam logic [32:0] VEC [8] = '{
    33'h0_A5C3_1E7F, 33'h1_A5C3_1E7F, 33'h0_8000_0001, 33'h1_8000_0001,
    33'h0_FFFF_0000, 33'h1_0000_FFFF, 33'h0_1234_5678, 33'h1_7FFE_C001
  };

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; isMaster = 1'b1; msbJust = 1'b0;
    playDisable = 1'b0; recDisable = 1'b0; loopback = 1'b0;
    bclkIn = 1'b0; lrclkIn = 1'b0; sdIn = 1'b0;
    txIdx = 0; txCnt = 0; popCount = 0; rxCount = 0; bclkToggles = 0;
    popPend = 1'b0; popSince = 1'b0; sdSeenHigh = 1'b0; lastBclk = 1'b0;
    lastPop = '0;
    for (int k = 0; k < 16; k++) txQ[k] = '0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk({bclkOut, lrclkOut, sdOut, txPop, rxPush} == 5'b0, "R1 reset outputs",
        {27'b0, bclkOut, lrclkOut, sdOut, txPop, rxPush}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // ---------- table walk: master loopback, sdIn held high (R3 R4 R5 R6 R7 R10) ----------
    for (int v = 0; v < 8; v++) begin
      startLink(1'b1, VEC[v][32], 1'b1, 1'b0, 1'b0);
      sdIn = 1'b1;
      txQ[0] = VEC[v][31:0];
      txCnt = 1;
      waitPushes(3, "R7 loopback push count");
      for (int k = 0; k < 3; k++) begin
        logic [31:0] e;
        e = VEC[v][32] ? ((k == 1) ? VEC[v][31:0] : '0)
                       : ((k == 0) ? VEC[v][31:0] : '0);
        chk(rxLog[k] == e, VEC[v][32] ? "R4 R6 R10 loopback word" : "R3 R6 R10 loopback word",
            rxLog[k], e);
      end
      chk(popCount == 1, "R6 one pop for one word", popCount, 1);
    end

    // ---------- R2: master clock shape ----------
    startLink(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(clkDrive == 1'b1, "R2 clkDrive in master", clkDrive, 1);
    begin
      int t0, t1, n, hi, lo;
      bit prevB, prevL;
      n = 0; t0 = 0; t1 = 0; prevB = 0;
      for (int c = 0; c < 200 && n < 2; c++) begin
        @(negedge clk);
        if (bclkOut && !prevB) begin
          if (n == 0) t0 = c; else t1 = c;
          n++;
        end
        prevB = bclkOut;
      end
      chk(t1 - t0 == 2 * DH, "R2 bit clock period", t1 - t0, 2 * DH);
      prevL = lrclkOut;
      while (!(lrclkOut && !prevL)) begin prevL = lrclkOut; @(negedge clk); end
      hi = 0; lo = 0; prevB = bclkOut;
      while (lrclkOut) begin
        @(negedge clk);
        if (bclkOut && !prevB && lrclkOut) hi++;
        prevB = bclkOut;
      end
      while (!lrclkOut) begin
        @(negedge clk);
        if (bclkOut && !prevB && !lrclkOut) lo++;
        prevB = bclkOut;
      end
      chk(hi == SW, "R2 R5 frame sync high slots", hi, SW);
      chk(lo == SW, "R2 R5 frame sync low slots", lo, SW);
    end

    // ---------- R10: no loopback, receiver takes sdIn ----------
    startLink(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    sdIn = 1'b1;
    txQ[0] = 32'h0; txCnt = 1;
    waitPushes(1, "R10 push from pin");
    chk(rxLog[0] == 32'hFFFF_FFFF, "R10 receiver uses sdIn", rxLog[0], 32'hFFFF_FFFF);

    // ---------- R8: playback disabled ----------
    startLink(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    txQ[0] = 32'hFFFF_FFFF; txQ[1] = 32'hFFFF_FFFF; txCnt = 2;
    waitPushes(2, "R8 pushes continue");
    chk(popCount == 0, "R8 no pops", popCount, 0);
    chk(rxLog[0] == 0 && rxLog[1] == 0, "R8 data low", rxLog[0] | rxLog[1], 0);
    chk(sdSeenHigh == 1'b0, "R8 sdOut never high", sdSeenHigh, 0);

    // ---------- R9: record disabled ----------
    startLink(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    txQ[0] = 32'h1357_9BDF; txQ[1] = 32'h2468_ACE0; txCnt = 2;
    repeat (1200) @(negedge clk);
    chk(rxCount == 0, "R9 no pushes", rxCount, 0);
    chk(popCount == 2, "R9 playback still runs", popCount, 2);

    // ---------- R1: both directions disabled, and enable low ----------
    startLink(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    txCnt = 2;
    repeat (300) @(negedge clk);
    chk(bclkToggles == 0 && popCount == 0 && rxCount == 0, "R1 both disabled idle",
        bclkToggles + popCount + rxCount, 0);
    startLink(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    enable = 1'b0;
    bclkToggles = 0;
    repeat (300) @(negedge clk);
    chk(bclkToggles == 0 && popCount == 0, "R1 enable low idle", bclkToggles + popCount, 0);

    // ---------- R11 with R3/R4: slave mode, both framings ----------
    for (int mode = 0; mode < 2; mode++) begin
      startLink(1'b0, mode[0], 1'b0, 1'b0, 1'b0);
      chk(clkDrive == 1'b0, "R2 clkDrive in slave", clkDrive, 0);
      sWords[0] = 32'hC001_8F0E; sWords[1] = 32'h5A5A_0FF1; sWords[2] = 32'h8001_7FFF;
      txQ[0] = 32'hDEAD_4321; txQ[1] = 32'h0F0F_F00F; txQ[2] = 32'h9ABC_0001; txCnt = 3;
      slaveRun(mode[0]);
      chk(rxCount == 3, "R7 R11 slave push count", rxCount, 3);
      for (int f = 0; f < 3; f++)
        chk(rxLog[f] == sWords[f], mode ? "R4 R5 R11 slave receive" : "R3 R5 R11 slave receive",
            rxLog[f], sWords[f]);
      for (int f = 0; f < 3; f++) begin
        logic [31:0] e;
        e = mode ? ((f == 0) ? 32'h0 : txQ[f - 1]) : txQ[f];
        chk(gotTx[f] == e, mode ? "R4 R6 R11 slave transmit" : "R3 R6 R11 slave transmit",
            gotTx[f], e);
      end
    end

    enable = 1'b0;
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule